// File: doc/BRIEF.md
# Table-Driven CCD Clock Waveform Sequencer

This block drives the clock and pixel-processing control lines of a CCD by replaying waveform tables held on chip. A table is an ordered list of steps. Each step is one output word that covers a bank of horizontal lines (serial clocks, summing well, reset gate, clamp, hold, convert start) and a bank of vertical lines (parallel clocks, transfer gate, line clamp). Every table has its own step length, counted in base ticks of 100 ns. The default settings are 10 ticks for horizontal tables and 25 ticks for vertical ones.

A host loads step words, a length and a step length into each table slot through a simple write port. The host then issues a start with a table index and a pass count. The block plays steps 0 to length-1 of that table. It repeats the whole table for the requested number of passes, with no gap between passes. When it finishes, it pulses `done` and drops `busy`. Separate slots hold the different operations: fast horizontal shift without read, slow horizontal readout, vertical shift down and vertical shift up. Each of these has left and right variants that drive different amplifier pairs. Between commands the lines keep the last step that was played.

Top module: `ccd_wave_player`

## Requirements
- R1: After reset, `hclk` and `vclk` are all zero and `busy`, `done` and `err` are low. All outputs come from registers. In a step word, bits [HW-1:0] drive `hclk` and bits [HW+VW-1:HW] drive `vclk`.
- R2: A write with `wr_en` high acts according to `wr_kind`. Code 0 stores `wr_data` as the word of step `wr_step` in table `wr_tab`. Code 1 stores the low `$clog2(NSTEP+1)` bits of `wr_data` as that table's step count. Code 2 stores the low GRID_W bits as its step length in base ticks. A pattern write with `wr_step` of NSTEP or more, or with `wr_tab` of NTAB or more, changes no stored step.
- R3: When `go` is high and `busy` is low at a clock edge, and `go_reps` is nonzero, the block latches `go_tab` and `go_reps`. Step 0 of that table appears on the outputs after that edge, and `busy` rises in the same cycle.
- R4: Each step stays on the outputs for exactly grid×TICK_DIV clock cycles. A stored step length of 0 acts as 1.
- R5: Steps 0 to length-1 play in order. The table plays `go_reps` passes back to back, so step 0 of the next pass follows the last step with no extra cycle.
- R6: When the last step of the last pass ends, `busy` falls and `done` goes high for exactly one cycle in the same cycle.
- R7: While idle, the outputs hold the last step that was played. They also keep that value in the cycle in which `busy` falls.
- R8: A start with `go_reps` equal to 0 pulses `done` in the next cycle. It leaves `busy` low and the outputs unchanged.
- R9: A `go` that arrives while `busy` is high is ignored, and the playback in progress continues unchanged. It sets `err`, and `err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; TICK_DIV cycles form one base tick |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | 0 step word, 1 step count, 2 step length, 3 no action |
| wr_tab | input | $clog2(NTAB) | Table slot being written |
| wr_step | input | $clog2(NSTEP) | Step index for word writes |
| wr_data | input | HW+VW | Write data |
| go | input | 1 | Start request |
| go_tab | input | $clog2(NTAB) | Table to play |
| go_reps | input | REP_W | Number of passes |
| hclk | output | HW | Horizontal (pixel) control lines |
| vclk | output | VW | Vertical (parallel) control lines |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Sticky start-while-busy flag |

## Verification
The bench builds the block with NTAB=4 and TICK_DIV=2. HW=16, VW=12 and NSTEP=40 keep their defaults, so the full 40-step slot and the 28-bit word are both covered. A prescaler of 2 makes a horizontal step 20 cycles and a vertical step 50 cycles. This keeps a two-pass run of a full 40-step table, a three-pass vertical table, a zero-length-step table and a single-step loop inside a short run. The flat step array puts a write to step 40 of table 1 on the address of step 0 of table 2. This makes the out-of-range write check observable on the outputs.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
   typedef enum logic [1:0] {
      WK_PATTERN = 2'd0,
      WK_LENGTH  = 2'd1,
      WK_GRID    = 2'd2,
      WK_NONE    = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/ccdseq_store.sv
module ccdseq_store
   import ccdseq_pkg::*;
#(
   parameter int WORD_W = 28,
   parameter int NTAB   = 8,
   parameter int NSTEP  = 40,
   parameter int GRID_W = 8,
   localparam int TAB_W  = $clog2(NTAB),
   localparam int STEP_W = $clog2(NSTEP),
   localparam int LEN_W  = $clog2(NSTEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_kind,
   input  logic [TAB_W-1:0]  wr_tab,
   input  logic [STEP_W-1:0] wr_step,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [TAB_W-1:0]  rd_tab,
   input  logic [STEP_W-1:0] rd_step,
   output logic [WORD_W-1:0] rd_word,
   output logic [LEN_W-1:0]  rd_len,
   output logic [GRID_W-1:0] rd_grid
);
   localparam int DEPTH  = NTAB * NSTEP;
   localparam int ADDR_W = $clog2(DEPTH);

   logic [WORD_W-1:0] steps_q [DEPTH];
   logic [LEN_W-1:0]  len_q   [NTAB];
   logic [GRID_W-1:0] grid_q  [NTAB];

   logic              wtab_ok, rtab_ok, wstep_ok;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [LEN_W-1:0]  len_raw;
   logic [GRID_W-1:0] grid_raw;

   assign wtab_ok  = 32'(wr_tab) < NTAB;
   assign rtab_ok  = 32'(rd_tab) < NTAB;
   assign wstep_ok = 32'(wr_step) < NSTEP;
   assign waddr    = ADDR_W'(wr_tab) * ADDR_W'(NSTEP) + ADDR_W'(wr_step);
   assign raddr    = ADDR_W'(rd_tab) * ADDR_W'(NSTEP) + ADDR_W'(rd_step);

   always_ff @(posedge clk) begin
      if (wr_en && wr_kind_e'(wr_kind) == WK_PATTERN && wtab_ok && wstep_ok)
         steps_q[waddr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NTAB; i++) begin
            len_q[i]  <= LEN_W'(1);
            grid_q[i] <= GRID_W'(1);
         end
      end else if (wr_en && wtab_ok) begin
         if (wr_kind_e'(wr_kind) == WK_LENGTH) len_q[wr_tab]  <= wr_data[LEN_W-1:0];
         if (wr_kind_e'(wr_kind) == WK_GRID)   grid_q[wr_tab] <= wr_data[GRID_W-1:0];
      end
   end

   always_comb begin
      len_raw  = rtab_ok ? len_q[rd_tab]  : LEN_W'(1);
      grid_raw = rtab_ok ? grid_q[rd_tab] : GRID_W'(1);
      rd_word  = rtab_ok ? steps_q[raddr] : '0;
      if (len_raw == '0)                  rd_len = LEN_W'(1);
      else if (len_raw > LEN_W'(NSTEP))   rd_len = LEN_W'(NSTEP);
      else                                rd_len = len_raw;
      rd_grid = (grid_raw == '0) ? GRID_W'(1) : grid_raw;
   end
endmodule

// File: rtl/ccdseq_timer.sv
module ccdseq_timer #(
   parameter int TICK_DIV = 10,
   parameter int GRID_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  logic [GRID_W-1:0] grid,
   output logic              step_end
);
   logic              tick;
   logic [GRID_W-1:0] gcnt;

   generate
      if (TICK_DIV == 1) begin : g_no_prescale
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(TICK_DIV);
         logic [PRE_W-1:0] pre;
         assign tick = (pre == PRE_W'(TICK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || restart) pre <= '0;
            else if (run)          pre <= tick ? '0 : pre + 1'b1;
         end
      end
   endgenerate

   assign step_end = run && tick && (gcnt == grid - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || restart)  gcnt <= '0;
      else if (run && tick)   gcnt <= step_end ? '0 : gcnt + 1'b1;
   end
endmodule

// File: rtl/ccdseq_play.sv
module ccdseq_play #(
   parameter int HW     = 16,
   parameter int VW     = 12,
   parameter int NTAB   = 8,
   parameter int NSTEP  = 40,
   parameter int REP_W  = 16,
   localparam int TAB_W  = $clog2(NTAB),
   localparam int STEP_W = $clog2(NSTEP),
   localparam int LEN_W  = $clog2(NSTEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [TAB_W-1:0]  go_tab,
   input  logic [REP_W-1:0]  go_reps,
   input  logic              step_end,
   input  logic [HW+VW-1:0]  rd_word,
   input  logic [LEN_W-1:0]  rd_len,
   output logic [TAB_W-1:0]  rd_tab,
   output logic [STEP_W-1:0] rd_step,
   output logic              restart,
   output logic [HW-1:0]     hclk,
   output logic [VW-1:0]     vclk,
   output logic              busy,
   output logic              done,
   output logic              err
);
   logic [TAB_W-1:0]  cur_tab;
   logic [STEP_W-1:0] step, nstep;
   logic [REP_W-1:0]  passes;
   logic              accept, last;

   assign accept  = go && !busy;
   assign restart = accept && (go_reps != '0);
   assign last    = (LEN_W'(step) + LEN_W'(1)) == rd_len;
   assign nstep   = last ? '0 : step + 1'b1;
   assign rd_tab  = busy ? cur_tab : go_tab;
   assign rd_step = busy ? nstep : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_tab <= '0;
         step    <= '0;
         passes  <= '0;
         hclk    <= '0;
         vclk    <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && busy) err <= 1'b1;
         if (accept) begin
            cur_tab <= go_tab;
            if (go_reps != '0) begin
               busy         <= 1'b1;
               step         <= '0;
               passes       <= go_reps;
               {vclk, hclk} <= rd_word;
            end else begin
               done <= 1'b1;
            end
         end else if (busy && step_end) begin
            if (last && passes == REP_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step         <= nstep;
               {vclk, hclk} <= rd_word;
               if (last) passes <= passes - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ccd_wave_player.sv
module ccd_wave_player #(
   parameter int HW       = 16,
   parameter int VW       = 12,
   parameter int NTAB     = 8,
   parameter int NSTEP    = 40,
   parameter int TICK_DIV = 10,
   parameter int GRID_W   = 8,
   parameter int REP_W    = 16,
   localparam int WORD_W = HW + VW,
   localparam int TAB_W  = $clog2(NTAB),
   localparam int STEP_W = $clog2(NSTEP),
   localparam int LEN_W  = $clog2(NSTEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_kind,
   input  logic [TAB_W-1:0]  wr_tab,
   input  logic [STEP_W-1:0] wr_step,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              go,
   input  logic [TAB_W-1:0]  go_tab,
   input  logic [REP_W-1:0]  go_reps,
   output logic [HW-1:0]     hclk,
   output logic [VW-1:0]     vclk,
   output logic              busy,
   output logic              done,
   output logic              err
);
   generate
      if (NTAB < 2)                    $error("NTAB must be at least 2");
      if (NSTEP < 2)                   $error("NSTEP must be at least 2");
      if (TICK_DIV < 1)                $error("TICK_DIV must be at least 1");
      if (HW < 1 || VW < 1)            $error("both output banks need a line");
      if (GRID_W > WORD_W)             $error("GRID_W wider than write data");
      if (LEN_W > WORD_W)              $error("step count wider than write data");
   endgenerate

   logic [TAB_W-1:0]  rd_tab;
   logic [STEP_W-1:0] rd_step;
   logic [WORD_W-1:0] rd_word;
   logic [LEN_W-1:0]  rd_len;
   logic [GRID_W-1:0] rd_grid;
   logic              restart, step_end;

   ccdseq_store #(
      .WORD_W(WORD_W), .NTAB(NTAB), .NSTEP(NSTEP), .GRID_W(GRID_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_kind(wr_kind), .wr_tab(wr_tab),
      .wr_step(wr_step), .wr_data(wr_data),
      .rd_tab(rd_tab), .rd_step(rd_step),
      .rd_word(rd_word), .rd_len(rd_len), .rd_grid(rd_grid)
   );

   ccdseq_timer #(
      .TICK_DIV(TICK_DIV), .GRID_W(GRID_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(busy),
      .grid(rd_grid), .step_end(step_end)
   );

   ccdseq_play #(
      .HW(HW), .VW(VW), .NTAB(NTAB), .NSTEP(NSTEP), .REP_W(REP_W)
   ) u_play (
      .clk(clk), .rst_n(rst_n),
      .go(go), .go_tab(go_tab), .go_reps(go_reps),
      .step_end(step_end), .rd_word(rd_word), .rd_len(rd_len),
      .rd_tab(rd_tab), .rd_step(rd_step), .restart(restart),
      .hclk(hclk), .vclk(vclk), .busy(busy), .done(done), .err(err)
   );
endmodule

// File: rtl/ccd_wave_player_chk.sv
module ccd_wave_player_chk #(
   parameter int HW    = 16,
   parameter int VW    = 12,
   parameter int REP_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [REP_W-1:0] go_reps,
   input logic [HW-1:0]    hclk,
   input logic [VW-1:0]    vclk,
   input logic             busy,
   input logic             done,
   input logic             err
);
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy && go_reps != '0) |=> busy);                         // R3
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R6
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                             // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(go && go_reps == '0)) |=> !done);                       // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go) |=> ($stable(hclk) && $stable(vclk)));              // R7
   AST_FINISH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($stable(hclk) && $stable(vclk)));                 // R7
   AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy && go_reps == '0) |=> (done && !busy));               // R8
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (go && busy) |=> err);                                             // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);                                                      // R9
endmodule

bind ccd_wave_player ccd_wave_player_chk #(
   .HW(HW), .VW(VW), .REP_W(REP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .go_reps(go_reps),
   .hclk(hclk), .vclk(vclk), .busy(busy), .done(done), .err(err)
);

// File: tb/ccd_wave_player_test.sv
module ccd_wave_player_test;
   localparam int PERIOD = 10;
   localparam int HW = 16, VW = 12, NTAB = 4, NSTEP = 40, TD = 2;
   localparam int GRID_W = 8, REP_W = 16;
   localparam int W = HW + VW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_kind = '0;
   logic [1:0] wr_tab = '0;
   logic [5:0] wr_step = '0;
   logic [W-1:0] wr_data = '0;
   logic go = 1'b0;
   logic [1:0] go_tab = '0;
   logic [REP_W-1:0] go_reps = '0;
   logic [HW-1:0] hclk;
   logic [VW-1:0] vclk;
   logic busy, done, err;

   int vec = 0, bad = 0;

   typedef struct { logic [W-1:0] word; int dur; } item_t;
   item_t sq[$];

   int lens [NTAB] = '{40, 5, 3, 1};
   int grids[NTAB] = '{10, 25, 0, 2};

   always #(PERIOD/2) clk = ~clk;

   ccd_wave_player #(
      .HW(HW), .VW(VW), .NTAB(NTAB), .NSTEP(NSTEP), .TICK_DIV(TD),
      .GRID_W(GRID_W), .REP_W(REP_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_tab(wr_tab), .wr_step(wr_step), .wr_data(wr_data),
      .go(go), .go_tab(go_tab), .go_reps(go_reps),
      .hclk(hclk), .vclk(vclk), .busy(busy), .done(done), .err(err)
   );

   function automatic logic [W-1:0] pat(int t, int s);
      logic [31:0] x;
      x = 32'((t * 64 + s + 1) * 32'h9E3779B1);
      return x[31:4];
   endfunction

   task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
      vec++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   task automatic wr(logic [1:0] k, int t, int s, logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_tab = 2'(t); wr_step = 6'(s); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // monitor: compares the outputs with the expected step stream, one cycle at a time
   initial begin
      item_t cur;
      int left = 0;
      forever begin
         @(negedge clk);
         if (left == 0 && sq.size() != 0) begin
            cur  = sq.pop_front();
            left = cur.dur;
         end
         if (left != 0) begin
            chk("R5 step stream", 64'({vclk, hclk}), 64'(cur.word)); // R4 R5
            left--;
         end
      end
   end

   // driver: starts a table, pushes the expected steps, checks the end of the command
   task automatic play(int t, int n, bit poke);
      int d, total, crossed;
      logic [W-1:0] lastw;
      d       = ((grids[t] == 0) ? 1 : grids[t]) * TD;
      total   = n * lens[t] * d;
      lastw   = pat(t, lens[t] - 1);
      crossed = 0;
      @(negedge clk);
      go = 1'b1; go_tab = 2'(t); go_reps = REP_W'(n);
      @(posedge clk);
      #1 go = 1'b0;
      for (int p = 0; p < n; p++)
         for (int s = 0; s < lens[t]; s++) begin
            item_t it;
            it.word = pat(t, s);
            it.dur  = d;
            sq.push_back(it);
         end
      @(negedge clk);
      chk("R3 busy after start", 64'(busy), 64'(1));
      if (poke) begin
         go = 1'b1; go_tab = 2'(t ^ 1); go_reps = REP_W'(1);
         @(negedge clk);
         go = 1'b0;
         crossed = 1;
         chk("R9 err after start while busy", 64'(err), 64'(1));
      end
      repeat (total - crossed) @(negedge clk);
      chk("R6 done pulse", 64'(done), 64'(1));
      chk("R6 busy low at done", 64'(busy), 64'(0));
      chk("R7 outputs at finish", 64'({vclk, hclk}), 64'(lastw));
      @(negedge clk);
      chk("R6 done one cycle", 64'(done), 64'(0));
      repeat (3) begin
         @(negedge clk);
         chk("R7 idle hold", 64'({vclk, hclk}), 64'(lastw));
      end
   endtask

   initial begin
      #(PERIOD * 180000);
      bad++;
      $display("FAIL R5 watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", 64'({vclk, hclk}), 64'(0));
      chk("R1 reset busy", 64'(busy), 64'(0));
      chk("R1 reset done", 64'(done), 64'(0));
      chk("R1 reset err", 64'(err), 64'(0));

      // R2: load all tables
      for (int t = 0; t < NTAB; t++) begin
         for (int s = 0; s < NSTEP; s++) wr(2'd0, t, s, pat(t, s));
         wr(2'd1, t, 0, W'(lens[t]));
         wr(2'd2, t, 0, W'(grids[t]));
      end
      // R2: step index 40 is out of range and would land on table 2 step 0
      wr(2'd0, 1, 40, 28'hA5A5A5A);

      play(0, 2, 1'b0);   // R4 R5: full 40-step horizontal table, two passes
      play(1, 3, 1'b1);   // R9: start while busy during a vertical table
      chk("R9 err sticky", 64'(err), 64'(1));
      play(2, 4, 1'b0);   // R2 R4: zero step length, aliased address untouched
      play(3, 3, 1'b0);   // R5: single-step loop

      // R8: zero pass count
      @(negedge clk);
      go = 1'b1; go_tab = 2'd1; go_reps = '0;
      @(posedge clk);
      #1 go = 1'b0;
      @(negedge clk);
      chk("R8 done on zero passes", 64'(done), 64'(1));
      chk("R8 busy stays low", 64'(busy), 64'(0));
      chk("R8 outputs unchanged", 64'({vclk, hclk}), 64'(pat(3, 0)));
      @(negedge clk);
      chk("R8 done one cycle", 64'(done), 64'(0));
      chk("R9 err still set", 64'(err), 64'(1));
      chk("R5 queue drained", 64'(sq.size()), 64'(0));
      report();
   end
endmodule